// File: doc/BRIEF.md
# Sensor Feature Aggregation Unit

This block turns a set of raw on-chip monitor readings into a compact statistics vector for a downstream health classifier. It watches six channels together: die temperature, supply voltage, ring-oscillator delay, instruction throughput, cache hit rate and branch prediction accuracy. A programmable timer sets how often all channels are captured. Each capture is one snapshot.

Every captured reading is clamped to that channel's own low/high range and rescaled to an unsigned 8-bit value. The value is then pushed into a per-channel history of the most recent 32 samples. Over a selectable window of the newest 4, 8, 16 or 32 samples, the block computes three features for each channel: the mean, the variance and the slope. The slope is the newest sample minus the oldest sample in the window.

After each snapshot the block offers one packed vector on a valid/ready output. The vector stays put until the consumer accepts it.

Top module: `sensor_feat_agg`

## Requirements
- R1: A snapshot is taken every `period`+1 clock cycles, with the first one on rising edge `period`+1 after reset is released. A vector built from a snapshot appears on the output one clock after that snapshot.
- R2: Each channel reading `x` is first clamped to [`lo`,`hi`], using that channel's fields of `range_lo` and `range_hi`. It is then scaled to floor((x-lo)*255/(hi-lo)).
- R3: The mean of channel c is floor(sum/W) over the W newest scaled samples. It is placed in bits [33c+7 : 33c] of `feat_data`.
- R4: The variance of channel c is floor(sum of squares/W) minus the square of the R3 mean. It is placed as 16 bits in bits [33c+23 : 33c+8].
- R5: The slope of channel c is the newest scaled sample minus the W-th newest, as a 9-bit two's-complement value. It is placed in bits [33c+32 : 33c+24].
- R6: `win_sel` values 0, 1, 2 and 3 select W = 4, 8, 16 and 32.
- R7: `feat_valid` is never raised for a snapshot while fewer than W snapshots have been taken since reset.
- R8: `feat_valid` and `feat_data` stay unchanged while `feat_valid` is high and `feat_ready` is low. Any snapshot that completes during that time produces no vector, but it still enters the history. `feat_valid` drops one clock after acceptance unless a new vector loads on that same edge.
- R9: While `rst_n` is low, `feat_valid` is 0 and `feat_data` is all zero.
- R10: A channel whose `hi` is less than or equal to its `lo` scales every reading to 0, so all three of its features read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period | input | 16 | Snapshot interval minus one, in cycles |
| win_sel | input | 2 | Statistics window select |
| raw_in | input | 72 | Raw readings, channel c in bits [12c+11:12c] |
| range_lo | input | 72 | Per-channel lower range limit |
| range_hi | input | 72 | Per-channel upper range limit |
| feat_ready | input | 1 | Consumer accepts the vector |
| feat_valid | output | 1 | Feature vector available |
| feat_data | output | 198 | Packed features, 33 bits per channel |

## Verification
The bench drives readings below and above each range, and also a channel with a collapsed range. A design that scaled before clamping, or divided by a zero span, would produce wrapped or garbage means. The window is widened from 4 to 32 partway through a run, which must silence the output until 32 snapshots exist; a fill check that only looked at the smallest window would emit vectors built from zeroed history. Back-pressure over several snapshot periods checks that held data does not change and that the dropped snapshots still shape the next vector. A reset in mid-run checks that stale history and a stale valid are both cleared.

// File: rtl/sfa_pkg.sv
`timescale 1ns/1ps
package sfa_pkg;

  // clamp a reading into [lo,hi] and rescale the span onto 0..full_scale
  function automatic int unsigned scale_reading(int unsigned x, int unsigned lo,
                                                int unsigned hi, int unsigned full_scale);
    int unsigned c;
    if (hi <= lo) return 0;
    c = x;
    if (c < lo) c = lo;
    if (c > hi) c = hi;
    return ((c - lo) * full_scale) / (hi - lo);
  endfunction

  // log2 of the active window length, saturated to the history depth
  function automatic int unsigned win_log(int unsigned sel, int unsigned log_min,
                                          int unsigned log_max);
    int unsigned l;
    l = log_min + sel;
    if (l > log_max) l = log_max;
    return l;
  endfunction

endpackage

// File: rtl/sfa_sample_timer.sv
`timescale 1ns/1ps
module sfa_sample_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt;

  assign tick = (cnt >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + PER_W'(1);
  end
endmodule

// File: rtl/sfa_norm.sv
`timescale 1ns/1ps
module sfa_norm #(
  parameter int RAW_W  = 12,
  parameter int NORM_W = 8
) (
  input  logic [RAW_W-1:0]  raw,
  input  logic [RAW_W-1:0]  lo,
  input  logic [RAW_W-1:0]  hi,
  output logic [NORM_W-1:0] norm
);
  localparam int unsigned FULL = (32'd1 << NORM_W) - 32'd1;

  always_comb
    norm = NORM_W'(sfa_pkg::scale_reading(32'(raw), 32'(lo), 32'(hi), FULL));
endmodule

// File: rtl/sfa_chan_stats.sv
`timescale 1ns/1ps
module sfa_chan_stats #(
  parameter int NORM_W  = 8,
  parameter int LOG_MIN = 2,
  parameter int LOG_MAX = 5,
  parameter int SEL_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [NORM_W-1:0]   din,
  input  logic [SEL_W-1:0]    win_sel,
  output logic [NORM_W-1:0]   mean,
  output logic [2*NORM_W-1:0] variance,
  output logic [NORM_W:0]     slope
);
  localparam int DEPTH = 1 << LOG_MAX;
  localparam int SUM_W = NORM_W + LOG_MAX;
  localparam int SQ_W  = 2 * NORM_W + LOG_MAX;
  localparam int VAR_W = 2 * NORM_W;
  localparam int SLP_W = NORM_W + 1;

  logic [NORM_W-1:0] hist [DEPTH];   // hist[0] is the newest sample
  logic [SUM_W-1:0]  sum;
  logic [SQ_W-1:0]   sq;
  logic [NORM_W-1:0] oldest;
  logic [VAR_W-1:0]  msq;
  int unsigned       wlog;
  int unsigned       wlen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (push) begin
      hist[0] <= din;
      for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
    end
  end

  always_comb begin
    wlog = sfa_pkg::win_log(32'(win_sel), LOG_MIN, LOG_MAX);
    wlen = 32'd1 << wlog;
  end

  always_comb begin
    sum    = '0;
    sq     = '0;
    oldest = hist[0];
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(wlen)) begin
        sum = sum + SUM_W'(hist[i]);
        sq  = sq + SQ_W'(hist[i]) * SQ_W'(hist[i]);
      end
      if (i == int'(wlen) - 1) oldest = hist[i];
    end
  end

  assign mean     = NORM_W'(sum >> wlog);
  assign msq      = VAR_W'(sq >> wlog);
  assign variance = msq - VAR_W'(mean) * VAR_W'(mean);
  assign slope    = SLP_W'(hist[0]) - SLP_W'(oldest);
endmodule

// File: rtl/sensor_feat_agg.sv
`timescale 1ns/1ps
module sensor_feat_agg #(
  parameter int NCH         = 6,
  parameter int RAW_W       = 12,
  parameter int NORM_W      = 8,
  parameter int LOG_MIN_WIN = 2,
  parameter int LOG_MAX_WIN = 5,
  parameter int SEL_W       = 2,
  parameter int PER_W       = 16,
  localparam int MEAN_W     = NORM_W,
  localparam int VAR_W      = 2 * NORM_W,
  localparam int SLP_W      = NORM_W + 1,
  localparam int FEAT_W     = MEAN_W + VAR_W + SLP_W,
  localparam int VEC_W      = NCH * FEAT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PER_W-1:0]   period,
  input  logic [SEL_W-1:0]   win_sel,
  input  logic [NCH*RAW_W-1:0] raw_in,
  input  logic [NCH*RAW_W-1:0] range_lo,
  input  logic [NCH*RAW_W-1:0] range_hi,
  input  logic               feat_ready,
  output logic               feat_valid,
  output logic [VEC_W-1:0]   feat_data
);
  localparam int MAX_WIN = 1 << LOG_MAX_WIN;
  localparam int CNT_W   = LOG_MAX_WIN + 1;

  // named internal events, also observed by the bound checker
  logic             sample_tick;
  logic             snap_pend;
  logic             fill_done;
  logic             snap_load;
  logic [CNT_W-1:0] fill_cnt;
  logic [CNT_W-1:0] win_len;
  logic [VEC_W-1:0] next_vec;

  sfa_sample_timer #(.PER_W(PER_W)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .period(period),
    .tick  (sample_tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [NORM_W-1:0] norm_v;
    logic [MEAN_W-1:0] mean_v;
    logic [VAR_W-1:0]  var_v;
    logic [SLP_W-1:0]  slp_v;

    sfa_norm #(.RAW_W(RAW_W), .NORM_W(NORM_W)) norm_i (
      .raw (raw_in  [c*RAW_W +: RAW_W]),
      .lo  (range_lo[c*RAW_W +: RAW_W]),
      .hi  (range_hi[c*RAW_W +: RAW_W]),
      .norm(norm_v)
    );

    sfa_chan_stats #(
      .NORM_W (NORM_W),
      .LOG_MIN(LOG_MIN_WIN),
      .LOG_MAX(LOG_MAX_WIN),
      .SEL_W  (SEL_W)
    ) stats_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (sample_tick),
      .din     (norm_v),
      .win_sel (win_sel),
      .mean    (mean_v),
      .variance(var_v),
      .slope   (slp_v)
    );

    assign next_vec[c*FEAT_W +: FEAT_W] = {slp_v, var_v, mean_v};
  end

  assign win_len   = CNT_W'(32'd1 << sfa_pkg::win_log(32'(win_sel), LOG_MIN_WIN, LOG_MAX_WIN));
  assign fill_done = (fill_cnt >= win_len);
  assign snap_load = snap_pend && fill_done && (!feat_valid || feat_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt  <= '0;
      snap_pend <= 1'b0;
    end else begin
      snap_pend <= sample_tick;
      if (sample_tick && fill_cnt != CNT_W'(MAX_WIN)) fill_cnt <= fill_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      feat_valid <= 1'b0;
      feat_data  <= '0;
    end else if (snap_load) begin
      feat_valid <= 1'b1;
      feat_data  <= next_vec;
    end else if (feat_valid && feat_ready) begin
      feat_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sensor_feat_agg_chk.sv
`timescale 1ns/1ps
module sensor_feat_agg_chk #(
  parameter int NCH    = 6,
  parameter int NORM_W = 8,
  parameter int PER_W  = 16,
  localparam int MEAN_W = NORM_W,
  localparam int VAR_W  = 2 * NORM_W,
  localparam int FEAT_W = MEAN_W + VAR_W + NORM_W + 1,
  localparam int VAR_LIM = (1 << (2 * NORM_W - 2)) + (1 << NORM_W)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [PER_W-1:0]      period,
  input logic                  feat_ready,
  input logic                  feat_valid,
  input logic [NCH*FEAT_W-1:0] feat_data,
  input logic                  sample_tick,
  input logic                  fill_done
);
  // R8: held vector does not move
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_valid && !feat_ready) |=> (feat_valid && $stable(feat_data)));

  // R7: a fresh vector only appears once the window has filled
  assert_no_early_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(feat_valid) |-> $past(fill_done));

  // R1: a fresh vector follows a snapshot by exactly one clock
  assert_load_after_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(feat_valid) |-> $past(sample_tick, 2));

  // R1: with a nonzero interval, snapshots are never back to back
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && period != '0) |=> (!sample_tick || period == '0));

  // R4: variance field stays within the range reachable from 8-bit samples
  for (genvar c = 0; c < NCH; c++) begin : g_var
    assert_var_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      feat_valid |-> (feat_data[c*FEAT_W + MEAN_W +: VAR_W] <= VAR_W'(VAR_LIM)));
  end
endmodule

bind sensor_feat_agg sensor_feat_agg_chk #(
  .NCH   (NCH),
  .NORM_W(NORM_W),
  .PER_W (PER_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .period     (period),
  .feat_ready (feat_ready),
  .feat_valid (feat_valid),
  .feat_data  (feat_data),
  .sample_tick(sample_tick),
  .fill_done  (fill_done)
);

// File: tb/sensor_feat_agg_tb_top.sv
`timescale 1ns/1ps
module sensor_feat_agg_tb_top;
  localparam int NCH = 6;
  localparam int RW  = 12;
  localparam int FW  = 33;
  localparam int VW  = NCH * FW;
  localparam int P   = 3;
  localparam int NV  = 12;

  // raw readings per step, channel order: temp, vdd, ring osc, throughput, hit rate, branch
  localparam int VEC [NV][NCH] = '{
    '{  50,    0, 2000,   0, 400,  900},
    '{ 600, 4095, 2100, 255, 550, 1000},
    '{1100, 2048, 2255, 128, 700, 3000},
    '{1500, 1024, 1500,  64, 520, 1000},
    '{ 300, 3000, 2050, 200, 590,    5},
    '{ 800,  100, 2200,  10, 505, 4095},
    '{1000,  512, 2010,  77, 560,    0},
    '{ 350, 3500, 2240, 240, 600, 1200},
    '{ 700, 2222, 2128,  33, 499,    1},
    '{ 900, 4000, 2064, 190, 575, 2000},
    '{ 150,    7, 2001,  99, 530, 1000},
    '{1050, 1111, 2222, 150, 580,  777}
  };
  localparam int LO [NCH] = '{100,    0, 2000,   0, 500, 1000};
  localparam int HI [NCH] = '{1100, 4095, 2255, 255, 600, 1000};

  logic              clk = 0;
  logic              rst_n = 0;
  logic [15:0]       period = 16'(P);
  logic [1:0]        win_sel = 0;
  logic [NCH*RW-1:0] raw_in = '0;
  logic [NCH*RW-1:0] range_lo;
  logic [NCH*RW-1:0] range_hi;
  logic              feat_ready = 1;
  logic              feat_valid;
  logic [VW-1:0]     feat_data;

  int n_chk = 0;
  int n_bad = 0;

  int      mh [NCH][32];
  int      m_fill = 0;
  bit      m_pend = 0;
  bit      m_v = 0;
  logic [VW-1:0] m_data = '0;

  always #5 clk = ~clk;

  sensor_feat_agg dut_i (
    .clk(clk), .rst_n(rst_n), .period(period), .win_sel(win_sel),
    .raw_in(raw_in), .range_lo(range_lo), .range_hi(range_hi),
    .feat_ready(feat_ready), .feat_valid(feat_valid), .feat_data(feat_data)
  );

  initial begin
    for (int c = 0; c < NCH; c++) begin
      range_lo[c*RW +: RW] = RW'(LO[c]);
      range_hi[c*RW +: RW] = RW'(HI[c]);
    end
  end

  task automatic chk(input string tag, input int got, input int exp, input string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  function automatic int scaled(int x, int lo, int hi);
    int v;
    if (hi <= lo) return 0;
    v = (x < lo) ? lo : x;
    v = (v > hi) ? hi : v;
    return ((v - lo) * 255) / (hi - lo);
  endfunction

  function automatic logic [VW-1:0] model_vec(int w);
    logic [VW-1:0] r;
    int s, s2, mn, vr, sl;
    r = '0;
    for (int c = 0; c < NCH; c++) begin
      s = 0; s2 = 0;
      for (int i = 0; i < w; i++) begin
        s  += mh[c][i];
        s2 += mh[c][i] * mh[c][i];
      end
      mn = s / w;
      vr = s2 / w - mn * mn;
      sl = mh[c][0] - mh[c][w-1];
      r[c*FW +: 8]      = 8'(mn);
      r[c*FW + 8 +: 16] = 16'(vr);
      r[c*FW + 24 +: 9] = 9'(sl);
    end
    return r;
  endfunction

  task automatic check_fields(input string ctx);
    for (int c = 0; c < NCH; c++) begin
      string t3, t4, t5;
      t3 = (c == 5) ? "R10" : "R2/R3";
      t4 = (c == 5) ? "R10" : "R4";
      t5 = (c == 5) ? "R10" : "R5";
      chk($sformatf("%s %s", t3, ctx), int'(feat_data[c*FW +: 8]),      int'(m_data[c*FW +: 8]),      $sformatf("ch%0d mean", c));
      chk($sformatf("%s %s", t4, ctx), int'(feat_data[c*FW + 8 +: 16]), int'(m_data[c*FW + 8 +: 16]), $sformatf("ch%0d variance", c));
      chk($sformatf("%s %s", t5, ctx), int'(feat_data[c*FW + 24 +: 9]), int'(m_data[c*FW + 24 +: 9]), $sformatf("ch%0d slope", c));
    end
  endtask

  // one snapshot interval: P+1 rising edges, snapshot taken on the last one
  task automatic step(input int sel, input bit r, input int idx, input string ctx);
    bit    was_v;
    int    w;
    string tagv;
    @(negedge clk);
    win_sel    = 2'(sel);
    feat_ready = r;
    for (int c = 0; c < NCH; c++) raw_in[c*RW +: RW] = RW'(VEC[idx][c]);
    w = 4 << sel;
    @(posedge clk);
    was_v = m_v;
    if (m_pend && m_fill >= w && (!m_v || r)) begin
      m_v = 1;
      m_data = model_vec(w);
    end else if (m_v && r) m_v = 0;
    @(negedge clk);
    tagv = (!m_v && m_fill < w) ? "R7" : ((was_v && !r) ? "R8" : "R1");
    chk($sformatf("%s %s", tagv, ctx), int'(feat_valid), int'(m_v), "valid");
    if (m_v) check_fields(ctx);
    @(posedge clk);
    if (m_v && r) m_v = 0;
    @(negedge clk);
    if (r) chk("R8", int'(feat_valid), int'(m_v), "valid after accept");
    repeat (P - 1) @(posedge clk);
    for (int c = 0; c < NCH; c++) begin
      for (int i = 31; i > 0; i--) mh[c][i] = mh[c][i-1];
      mh[c][0] = scaled(VEC[idx][c], LO[c], HI[c]);
    end
    if (m_fill < 32) m_fill++;
    m_pend = 1;
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 32; i++) mh[c][i] = 0;
    m_fill = 0; m_pend = 0; m_v = 0; m_data = '0;
  endtask

  task automatic release_reset();
    @(posedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    int k;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", int'(feat_valid), 0, "valid in reset");
    chk("R9", int'(feat_data == '0), 1, "data cleared in reset");
    release_reset();

    // table walk, window of 4
    for (int i = 0; i < NV; i++) step(0, 1, i, "w4");

    // widen to 32: output silent until 32 snapshots exist (R6, R7)
    k = 0;
    for (int i = 0; i < 21; i++) begin
      step(3, 1, k, "R6 w32");
      k = (k + 5) % NV;
    end
    // window of 8 and 16 (R6)
    for (int i = 0; i < 4; i++) step(1, 1, (i * 7) % NV, "R6 w8");
    for (int i = 0; i < 4; i++) step(2, 1, (i * 3 + 1) % NV, "R6 w16");

    // back-pressure: held across snapshots, then accepted (R8)
    for (int i = 0; i < 3; i++) step(1, 0, (i + 2) % NV, "R8 hold");
    for (int i = 0; i < 2; i++) step(1, 1, (i + 9) % NV, "R8 release");

    // reset mid-run while a vector is pending (R9), then refill (R7)
    @(negedge clk);
    feat_ready = 0;
    rst_n = 0;
    model_reset();
    @(negedge clk);
    chk("R9", int'(feat_valid), 0, "valid after mid-run reset");
    chk("R9", int'(feat_data == '0), 1, "data after mid-run reset");
    release_reset();
    for (int i = 0; i < 6; i++) step(0, 1, (i * 5 + 3) % NV, "R7 refill");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule